// File: doc/BRIEF.md
# Affine Prefetching Operand Streamer

The streamer feeds a compute unit from a banked shared SRAM. A six-level nested-loop address generator produces a stream of 64-bit word addresses. Each address is the affine sum of a base and each loop index times its stride. This is enough to describe strided matrix tiles and implicit im2col walks for convolutions of any stride, kernel size and channel count. Software writes the base, the last index of each loop and each stride through a small register port, then pulses `start`.

The address stream is dealt round-robin onto several independent 64-bit read channels. Each channel has one request slot facing the SRAM crossbar and a small FIFO for returned data. A channel accepts a new address whenever its FIFO still has room once reads already in flight are counted. Reads therefore run ahead of the consumer and do not wait for demand. When every channel holds a word, the streamer presents one wide operand beat built from the FIFO heads. A completion flag rises once the whole loop nest has been walked and every channel has drained.

Top module: `opstream_top`

## Requirements
- R1: Configuration writes with `cfg_we` high store `cfg_wdata` into the register chosen by `cfg_sel`. Select 0 is the base word address, selects 1 to 6 are the last index of loops 0 to 5 (loop 0 is innermost), and selects 7 to 12 are the strides of loops 0 to 5. A `start` pulse begins a walk from all indices at zero.
- R2: Loop 0 advances fastest. A loop whose index equals its programmed last value returns to zero and carries into the next outer loop. The walk ends after the step where every index is at its last value. Each address is (base + sum of index times stride) modulo 2^ADDR_W, with strides read as two's complement.
- R3: The k-th generated address (k from 0) is read on channel k mod NUM_CH. Output beat j carries, in bits [64c+63:64c], the word at address j*NUM_CH+c. The number of addresses in a walk must be a multiple of NUM_CH.
- R4: Each channel presents the full word address on its slice of `mem_addr`. Bits [4:0] select one of 32 banks, and the bits above select the row in that bank.
- R5: A request that is not granted stays asserted, with its address unchanged, until a cycle in which `mem_gnt` is high for that channel.
- R6: Read data for a request granted in cycle t is taken from the channel's slice of `mem_rdata` in cycle t+1 and goes into that channel's FIFO.
- R7: Reads are issued ahead of demand. With the consumer stalled, each channel completes exactly FIFO_DEPTH grants and then stops requesting, and no FIFO overflows.
- R8: `out_valid` is high exactly when every channel FIFO holds a word. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R9: `done` is low while any beat of the walk is still to be consumed. It rises once the walk has ended and every slot, in-flight read and FIFO is empty, and it falls in the cycle after `start`.
- R10: After reset, `done`, `out_valid` and every `mem_req` bit are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration register select |
| cfg_wdata | input | ADDR_W | Configuration write value |
| start | input | 1 | Begin a walk |
| done | output | 1 | Walk finished and all channels drained |
| mem_req | output | NUM_CH | Per-channel read request |
| mem_addr | output | NUM_CH*ADDR_W | Per-channel word address |
| mem_gnt | input | NUM_CH | Per-channel grant |
| mem_rdata | input | NUM_CH*64 | Per-channel read data, one cycle after grant |
| out_valid | output | 1 | Operand beat available |
| out_ready | input | 1 | Consumer accepts the beat |
| out_data | output | NUM_CH*64 | Operand beat, channel 0 in the low bits |

## Verification
The bench builds the streamer with four channels, a 14-bit word address and the smallest legal FIFO depth of two. At that depth the credit rule is tight: one slot and one in-flight read already fill the FIFO, so any off-by-one in the occupancy count shows up as an overflow or a lost word. Four channels over 32 banks make a stride of 32 send every channel to the same bank, which forces serialised grants. The 14-bit address lets a base near the top of memory wrap to zero.

// File: rtl/opstream_pkg.sv
// Shared constants of the operand streamer: loop count, word width and the
// configuration select encoding. Assumes a word-addressed SRAM of 64-bit words.
package opstream_pkg;
    localparam int unsigned LOOP_DIMS  = 6;
    localparam int unsigned WORD_W     = 64;
    localparam int unsigned CFG_SEL_W  = 4;
    localparam int unsigned BANK_BITS  = 5;
    localparam logic [CFG_SEL_W-1:0] SEL_BASE    = 4'd0;
    localparam logic [CFG_SEL_W-1:0] SEL_LAST0   = 4'd1;
    localparam logic [CFG_SEL_W-1:0] SEL_STRIDE0 = 4'd7;
endpackage

// File: rtl/opstream_agu.sv
// Six-level affine address generator. Holds the base, per-loop last index and
// per-loop stride, walks the loop nest one step per accepted address and
// raises 'finished' after the final step. Assumes configuration is stable
// while a walk is running.
module opstream_agu
    import opstream_pkg::*;
#(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned IDX_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_SEL_W-1:0] cfg_sel,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    input  logic                 start,
    output logic                 addr_valid,
    input  logic                 addr_ready,
    output logic [ADDR_W-1:0]    addr,
    output logic                 finished
);
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  last_q   [LOOP_DIMS];
    logic [ADDR_W-1:0] stride_q [LOOP_DIMS];
    logic [IDX_W-1:0]  idx_q    [LOOP_DIMS];
    logic              busy_q, fin_q;
    logic [LOOP_DIMS-1:0] wrap, carry;
    logic              all_last;
    logic              fire;

    assign fire       = busy_q && addr_ready;
    assign addr_valid = busy_q;
    assign finished   = fin_q;

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            for (int d = 0; d < LOOP_DIMS; d++) begin
                last_q[d]   <= '0;
                stride_q[d] <= '0;
            end
        end else if (cfg_we) begin
            if (cfg_sel == SEL_BASE) base_q <= cfg_wdata;
            for (int d = 0; d < LOOP_DIMS; d++) begin
                if (cfg_sel == SEL_LAST0 + CFG_SEL_W'(d))   last_q[d]   <= cfg_wdata[IDX_W-1:0];
                if (cfg_sel == SEL_STRIDE0 + CFG_SEL_W'(d)) stride_q[d] <= cfg_wdata;
            end
        end
    end

    // Per-loop wrap detection and the carry chain from the innermost loop.
    always_comb begin
        logic run;
        run = 1'b1;
        for (int d = 0; d < LOOP_DIMS; d++) begin
            wrap[d]  = (idx_q[d] == last_q[d]);
            carry[d] = run;
            run      = run & wrap[d];
        end
        all_last = run;
    end

    // Affine sum of base and index-stride products, modulo 2^ADDR_W.
    always_comb begin
        logic [ADDR_W-1:0] acc;
        acc = base_q;
        for (int d = 0; d < LOOP_DIMS; d++) begin
            acc = acc + ADDR_W'(idx_q[d]) * stride_q[d];
        end
        addr = acc;
    end

    // Loop index stepping and walk state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            fin_q  <= 1'b0;
            for (int d = 0; d < LOOP_DIMS; d++) idx_q[d] <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            fin_q  <= 1'b0;
            for (int d = 0; d < LOOP_DIMS; d++) idx_q[d] <= '0;
        end else if (fire) begin
            if (all_last) begin
                busy_q <= 1'b0;
                fin_q  <= 1'b1;
            end
            for (int d = 0; d < LOOP_DIMS; d++) begin
                if (carry[d]) idx_q[d] <= wrap[d] ? '0 : idx_q[d] + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/opstream_chan.sv
// One 64-bit read channel: a request slot that holds its address until
// granted, a one-cycle in-flight marker, and a FIFO for returned words.
// Accepts a new address only while slot, in-flight read and FIFO contents
// together stay below DEPTH. Assumes 'pop' only when 'has_data'.
module opstream_chan
    import opstream_pkg::*;
#(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_valid,
    input  logic [ADDR_W-1:0] take_addr,
    output logic              can_take,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] head,
    output logic              has_data,
    input  logic              pop,
    output logic              fifo_push,
    output logic              fifo_full,
    output logic              idle
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic              slot_v;
    logic [ADDR_W-1:0] slot_a;
    logic              inflight_q;
    logic [WORD_W-1:0] store_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;

    assign can_take  = !slot_v && ((int'(count) + int'(inflight_q)) < int'(DEPTH));
    assign mem_req   = slot_v;
    assign mem_addr  = slot_a;
    assign fifo_push = inflight_q;
    assign fifo_full = (int'(count) == int'(DEPTH));
    assign has_data  = (count != '0);
    assign head      = store_q[rd_ptr];
    assign idle      = !slot_v && !inflight_q && (count == '0);

    // Request slot: load on accept, release on grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v     <= 1'b0;
            slot_a     <= '0;
            inflight_q <= 1'b0;
        end else begin
            inflight_q <= slot_v && mem_gnt;
            if (take_valid) begin
                slot_v <= 1'b1;
                slot_a <= take_addr;
            end else if (slot_v && mem_gnt) begin
                slot_v <= 1'b0;
            end
        end
    end

    // FIFO data storage, written the cycle after a grant.
    always_ff @(posedge clk) begin
        if (inflight_q) store_q[wr_ptr] <= mem_rdata;
    end

    // FIFO pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (inflight_q) wr_ptr <= (int'(wr_ptr) == int'(DEPTH) - 1) ? '0 : wr_ptr + PTR_W'(1);
            if (pop)        rd_ptr <= (int'(rd_ptr) == int'(DEPTH) - 1) ? '0 : rd_ptr + PTR_W'(1);
            case ({inflight_q, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/opstream_top.sv
// Operand streamer top: one affine address generator dealing addresses
// round-robin onto NUM_CH prefetching read channels, with the FIFO heads
// joined into one operand beat. Assumes the walk length is a multiple of
// NUM_CH and that start is pulsed only while idle or done.
module opstream_top
    import opstream_pkg::*;
#(
    parameter int unsigned NUM_CH     = 4,
    parameter int unsigned ADDR_W     = 14,
    parameter int unsigned IDX_W      = 8,
    parameter int unsigned FIFO_DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [CFG_SEL_W-1:0]       cfg_sel,
    input  logic [ADDR_W-1:0]          cfg_wdata,
    input  logic                       start,
    output logic                       done,
    output logic [NUM_CH-1:0]          mem_req,
    output logic [NUM_CH*ADDR_W-1:0]   mem_addr,
    input  logic [NUM_CH-1:0]          mem_gnt,
    input  logic [NUM_CH*WORD_W-1:0]   mem_rdata,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [NUM_CH*WORD_W-1:0]   out_data
);
    localparam int unsigned RR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic              agu_valid, agu_ready, agu_fin;
    logic [ADDR_W-1:0] agu_addr;
    logic [RR_W-1:0]   rr_q;
    logic [NUM_CH-1:0] can_take, take_valid, has_data, idle;
    logic [NUM_CH-1:0] fifo_push, fifo_full;
    logic              beat_pop;

    opstream_agu #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_agu (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start(start), .addr_valid(agu_valid),
        .addr_ready(agu_ready), .addr(agu_addr), .finished(agu_fin)
    );

    assign agu_ready = can_take[rr_q];
    assign out_valid = &has_data;
    assign beat_pop  = out_valid && out_ready;
    assign done      = agu_fin && (&idle);

    // Round-robin dealing pointer: channel that receives the next address.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            rr_q <= '0;
        end else if (agu_valid && agu_ready) begin
            rr_q <= (int'(rr_q) == int'(NUM_CH) - 1) ? '0 : rr_q + RR_W'(1);
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign take_valid[c] = agu_valid && (rr_q == RR_W'(c)) && can_take[c];

        opstream_chan #(.ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .take_valid(take_valid[c]), .take_addr(agu_addr), .can_take(can_take[c]),
            .mem_req(mem_req[c]), .mem_addr(mem_addr[c*ADDR_W +: ADDR_W]),
            .mem_gnt(mem_gnt[c]), .mem_rdata(mem_rdata[c*WORD_W +: WORD_W]),
            .head(out_data[c*WORD_W +: WORD_W]), .has_data(has_data[c]), .pop(beat_pop),
            .fifo_push(fifo_push[c]), .fifo_full(fifo_full[c]), .idle(idle[c])
        );
    end
endmodule

// File: rtl/opstream_chk.sv
// Property checker for the operand streamer, bound to every opstream_top
// instance. Observes ports plus the per-channel FIFO push/full strobes.
module opstream_chk
    import opstream_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 14
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic                     done,
    input logic [NUM_CH-1:0]        mem_req,
    input logic [NUM_CH*ADDR_W-1:0] mem_addr,
    input logic [NUM_CH-1:0]        mem_gnt,
    input logic                     out_valid,
    input logic                     out_ready,
    input logic [NUM_CH*WORD_W-1:0] out_data,
    input logic [NUM_CH-1:0]        fifo_push,
    input logic [NUM_CH-1:0]        fifo_full
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // R5: a refused request keeps its request and address.
        a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
            mem_req[c] && !mem_gnt[c] |=> mem_req[c] && $stable(mem_addr[c*ADDR_W +: ADDR_W]));
        // R7: no write into a full FIFO that is not being drained.
        a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            fifo_full[c] && !(out_valid && out_ready) |-> !fifo_push[c]);
    end

    // R8: a stalled beat holds its value.
    a_r8_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    // R9: completion implies nothing left to read or deliver.
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid && (mem_req == '0));
    // R9: start clears completion.
    a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);
endmodule

bind opstream_top opstream_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_opstream_top.sv
`timescale 1ns/1ps
module sim_opstream_top;
    localparam int NCH = 4, DEPTH = 2, AW = 14, BANKS = 32, ROWS = 512;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0, start = 1'b0, done, out_valid, out_ready;
    logic [3:0] cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [NCH-1:0] mem_req, mem_gnt;
    logic [NCH*AW-1:0] mem_addr;
    logic [NCH*64-1:0] mem_rdata, out_data;

    opstream_top #(.NUM_CH(NCH), .ADDR_W(AW), .IDX_W(8), .FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .start(start), .done(done), .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

    always #10 clk = ~clk;

    int checks = 0, errors = 0, gnt_total = 0;
    bit hold_ready = 0, rand_ready = 0, rand_refuse = 0, finished = 0;
    logic [NCH*64-1:0] exp_q[$];
    logic [63:0] sram [BANKS][ROWS];
    logic [NCH-1:0] gnt_prev = '0;
    logic [AW-1:0] addr_prev [NCH];

    function automatic logic [63:0] word_of(input logic [AW-1:0] a);
        return {32'(a) ^ 32'hDEAD_0000, 32'(a) * 32'd2654435761};
    endfunction

    task automatic chk(input string req, input logic [NCH*64-1:0] act, input logic [NCH*64-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Bank-array SRAM, grant model and scoreboard monitor, all at the falling edge.
    initial begin
        bit [BANKS-1:0] used;
        for (int b = 0; b < BANKS; b++)
            for (int r = 0; r < ROWS; r++) sram[b][r] = word_of(AW'(r * BANKS + b));
        mem_gnt = '0; mem_rdata = '0; out_ready = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                gnt_prev = '0; mem_gnt = '0; out_ready = 1'b0;
            end else begin
                for (int c = 0; c < NCH; c++)
                    if (gnt_prev[c]) mem_rdata[c*64 +: 64] = sram[addr_prev[c][4:0]][addr_prev[c][AW-1:5]];
                used = '0;
                for (int c = 0; c < NCH; c++) begin
                    logic [4:0] b;
                    logic g;
                    g = 1'b0;
                    b = mem_addr[c*AW +: 5];
                    if (mem_req[c] && !used[b] && !(rand_refuse && $urandom_range(0, 3) == 0)) begin
                        g = 1'b1; used[b] = 1'b1; gnt_total++;
                    end
                    mem_gnt[c] = g; gnt_prev[c] = g; addr_prev[c] = mem_addr[c*AW +: AW];
                end
                out_ready = hold_ready ? 1'b0 : (rand_ready ? 1'($urandom_range(0, 1)) : 1'b1);
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) chk("R3 unexpected beat", out_data, '0);
                    else chk("R2/R3/R4/R6 beat", out_data, exp_q.pop_front());
                end
            end
        end
    end

    task automatic cfg_write(input int sel, input int val);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_wdata = AW'(val);
        @(negedge clk); cfg_we = 1'b0;
    endtask

    // Driver: program a walk, push the expected beats, start and wait for completion.
    task automatic run_case(input string name, input int base, input int lst[6], input int str[6],
                            input bit rrdy, input bit rref, input int stall);
        int addrs[$];
        logic [NCH*64-1:0] beat;
        bit early_done;
        int guard;
        cfg_write(0, base);
        for (int d = 0; d < 6; d++) begin cfg_write(1 + d, lst[d]); cfg_write(7 + d, str[d]); end
        for (int i5 = 0; i5 <= lst[5]; i5++) for (int i4 = 0; i4 <= lst[4]; i4++)
        for (int i3 = 0; i3 <= lst[3]; i3++) for (int i2 = 0; i2 <= lst[2]; i2++)
        for (int i1 = 0; i1 <= lst[1]; i1++) for (int i0 = 0; i0 <= lst[0]; i0++)
            addrs.push_back((base + i0*str[0] + i1*str[1] + i2*str[2] + i3*str[3]
                             + i4*str[4] + i5*str[5]) & ((1 << AW) - 1));
        for (int j = 0; j < addrs.size() / NCH; j++) begin
            for (int c = 0; c < NCH; c++) beat[c*64 +: 64] = word_of(AW'(addrs[j*NCH + c]));
            exp_q.push_back(beat);
        end
        rand_ready = rrdy; rand_refuse = rref; hold_ready = (stall > 0); gnt_total = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk({"R9 done cleared after start: ", name}, NCH*64'(done), '0);
        if (stall > 0) begin
            repeat (stall) @(negedge clk);
            chk({"R7 prefetch grants while stalled: ", name}, NCH*64'(gnt_total), NCH*64'(NCH * DEPTH));
            chk({"R7 requests stop when FIFOs full: ", name}, NCH*64'(mem_req), '0);
            chk({"R8 valid while stalled: ", name}, NCH*64'(out_valid), NCH*64'(1));
            hold_ready = 0;
        end
        early_done = 0; guard = 0;
        while (exp_q.size() > 0 && guard < 20000) begin
            @(negedge clk); guard++;
            if (exp_q.size() > 0 && done) early_done = 1;
        end
        chk({"R9 done low while beats pending: ", name}, NCH*64'(early_done), '0);
        chk({"R3 all beats delivered: ", name}, NCH*64'(exp_q.size()), '0);
        repeat (3) @(negedge clk);
        chk({"R9 done after drain: ", name}, NCH*64'(done), NCH*64'(1));
        chk({"R8 no beat after walk: ", name}, NCH*64'(out_valid), '0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 done after reset", NCH*64'(done), '0);
        chk("R10 out_valid after reset", NCH*64'(out_valid), '0);
        chk("R10 mem_req after reset", NCH*64'(mem_req), '0);
        // R1 R2 R3: linear run, consumer always ready.
        run_case("linear", 100, '{15, 0, 0, 0, 0, 0}, '{1, 0, 0, 0, 0, 0}, 0, 0, 0);
        // R2: two-level strided tile under random backpressure (R8).
        run_case("tile", 5, '{3, 3, 0, 0, 0, 0}, '{1, 40, 0, 0, 0, 0}, 1, 0, 0);
        // R2: implicit im2col walk: channel, kx, ky, ox, oy; random refusals (R5).
        run_case("im2col", 200, '{1, 2, 1, 1, 1, 0}, '{2'd1, 2, 20, 4, 40, 0}, 1, 1, 0);
        // R4 R5: stride 32 puts every channel on bank 7.
        run_case("bank clash", 7, '{15, 0, 0, 0, 0, 0}, '{32, 0, 0, 0, 0, 0}, 1, 1, 0);
        // R2: negative stride and address wrap past the top of memory.
        run_case("wrap", 16380, '{3, 1, 1, 0, 0, 0}, '{1, -8, 8, 0, 0, 0}, 0, 1, 0);
        // R7: consumer stalled, prefetch limited by FIFO depth.
        run_case("stall", 0, '{63, 0, 0, 0, 0, 0}, '{1, 0, 0, 0, 0, 0}, 0, 0, 40);
        summary();
    end
endmodule